// File: doc/BRIEF.md
# SPI Serial EEPROM Slave Controller

This block is the serial front end of a byte-addressed nonvolatile store, with the store itself modelled as an on-chip register array. A host talks to it over a four-wire SPI link in mode 0. Chip select, serial clock and serial data in are brought into the system clock domain through synchronizers. Serial data out comes with a separate output-enable that stands in for a tri-state pad. Five instructions are decoded: set write enable, read status, write status, read data and write data.

Reads stream without limit. The array pointer steps after every byte and wraps from the top address to zero. A write carries one data byte, and it is committed only when chip select rises straight after the last data bit. A committed write starts a simulated programming cycle that holds a busy flag for a set number of system clocks. While that flag is high, only status reads are serviced. Whether a given address or the status register may be written is decided outside the block. The block presents the target on its protection port and reads back one allow bit when the frame closes.

The array has 2^`ADDR_W` bytes. The default of 10 keeps elaboration small, and 15 gives the full 32768-byte part.

Top module: `ee_spi_slave`

## Requirements
- R1: After reset the status byte reads 0x00, `miso_oe` is low and `prot_cfg` is 0.
- R2: A frame holding only opcode 0x06 (exactly 8 clocks) sets the write-enable flag, which is status bit 1.
- R3: Opcode 0x03 followed by a 16-bit address (sent MSB first, bits at and above `ADDR_W` ignored) returns the addressed byte MSB first. Its first bit is driven after the serial clock falling edge that follows the 24th rising edge.
- R4: A read that continues past its first byte returns the following addresses in turn, and wraps from address 2^`ADDR_W`-1 to 0.
- R5: Opcode 0x02 (address, then one data byte) changes nothing and starts no busy period unless the write-enable flag was set in an earlier frame.
- R6: A write or status write commits only if chip select rises after exactly 32 (write) or 16 (status write) serial clocks. A frame with one clock fewer or one more commits nothing.
- R7: A committed write holds status bit 0 at 1 for `PROG_CYCLES` system clocks, after which it reads 0.
- R8: While status bit 0 is 1, every frame other than status read (0x05) is ignored: a data read never enables `miso`, and 0x06 does not set the write-enable flag.
- R9: The write-enable flag clears at the end of every serviced write or status-write frame, whether it committed or not.
- R10: Opcode 0x01 followed by one byte stores bits 7..2 into status bits 7..2, also seen on `prot_cfg`. Status bits 1..0 cannot be written.
- R11: A commit happens only when `prot_ok` is high as the frame ends. `prot_addr` carries the frame's address and `prot_is_status` is high for a status write. A refused commit leaves memory unchanged and starts no busy period.
- R12: `miso_oe` is low whenever chip select is high.
- R13: A status read keeps returning the status byte for as many bytes as the host clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, mode 0 |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for `miso` |
| prot_addr | output | ADDR_W | Array address of the current frame, for the protection unit |
| prot_is_status | output | 1 | The current frame is a status write |
| prot_ok | input | 1 | Protection unit allows the pending commit |
| prot_cfg | output | 6 | Stored status bits 7..2 for the protection unit |

## Verification
The bench probes the exact bit count at chip-select release with 31-bit and 33-bit write frames. A design that counted loosely would program on a truncated frame or on one with a trailing bit. It reads across the top address, where a design without the wrap would return data from beyond the array or stall, and it reads an address with its high bits set, which must alias to low memory. It sends a data read and a write-enable while busy, where a faulty lockout would drive `miso` or latch the flag. It also checks that a refused or malformed write still drops the write-enable flag, and that status bits 1..0 survive a status write of all ones.

// File: rtl/ee_pkg.sv
package ee_pkg;

  localparam logic [7:0] OPC_WREN  = 8'h06;
  localparam logic [7:0] OPC_RDSR  = 8'h05;
  localparam logic [7:0] OPC_WRSR  = 8'h01;
  localparam logic [7:0] OPC_READ  = 8'h03;
  localparam logic [7:0] OPC_WRITE = 8'h02;

  // serial clock counts that close each phase of a frame
  localparam int unsigned OPC_BITS   = 8;
  localparam int unsigned ADDR_BITS  = 16;
  localparam int unsigned HDR_BITS   = OPC_BITS + ADDR_BITS;
  localparam int unsigned WRSR_BITS  = OPC_BITS + 8;
  localparam int unsigned WRITE_BITS = HDR_BITS + 8;
  localparam int unsigned CNT_W      = 6;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_WREN,
    CMD_RDSR,
    CMD_WRSR,
    CMD_READ,
    CMD_WRITE
  } cmd_e;

  function automatic cmd_e decode_op(input logic [7:0] op);
    cmd_e c;
    case (op)
      OPC_WREN:  c = CMD_WREN;
      OPC_RDSR:  c = CMD_RDSR;
      OPC_WRSR:  c = CMD_WRSR;
      OPC_READ:  c = CMD_READ;
      OPC_WRITE: c = CMD_WRITE;
      default:   c = CMD_NONE;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/ee_spi_sync.sv
module ee_spi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n_i,
  input  logic sck_i,
  input  logic mosi_i,
  output logic sel,
  output logic sck_rise,
  output logic sck_fall,
  output logic mosi_s,
  output logic frame_end
);

  localparam int MSB = STAGES - 1;

  logic [STAGES-1:0] cs_q, sck_q, mo_q;
  logic [STAGES-1:0] cs_d, sck_d, mo_d;
  logic              cs_last_q, sck_last_q;

  always_comb begin
    cs_d  = {cs_q[STAGES-2:0],  cs_n_i};
    sck_d = {sck_q[STAGES-2:0], sck_i};
    mo_d  = {mo_q[STAGES-2:0],  mosi_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q       <= '1;
      sck_q      <= '0;
      mo_q       <= '0;
      cs_last_q  <= 1'b1;
      sck_last_q <= 1'b0;
    end else begin
      cs_q       <= cs_d;
      sck_q      <= sck_d;
      mo_q       <= mo_d;
      cs_last_q  <= cs_q[MSB];
      sck_last_q <= sck_q[MSB];
    end
  end

  assign sel       = !cs_q[MSB];
  assign sck_rise  = sel && sck_q[MSB] && !sck_last_q;
  assign sck_fall  = sel && !sck_q[MSB] && sck_last_q;
  assign mosi_s    = mo_q[MSB];
  assign frame_end = cs_q[MSB] && !cs_last_q;

  a_r12_end_only_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> !sel);

endmodule

// File: rtl/ee_frame.sv
module ee_frame
  import ee_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic              mosi_s,
  input  logic              frame_end,
  input  logic              busy,
  input  logic [7:0]        status,
  input  logic [7:0]        mem_rdata,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [7:0]        cmd_data,
  output logic              fe_wren,
  output logic              fe_write,
  output logic              fe_wrsr,
  output logic              fe_full,
  output logic              is_status_wr,
  output logic              miso,
  output logic              miso_oe
);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [15:0]       sh_q, sh_d, sh_n;
  cmd_e              cmd_q, cmd_d;
  logic              ign_q, ign_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              go_q, go_d;
  logic              stat_q, stat_d;
  logic [2:0]        bidx_q, bidx_d;
  logic              miso_q, miso_d;
  logic              oe_q, oe_d;
  logic [7:0]        src_byte;
  logic              src_bit;

  assign sh_n     = {sh_q[14:0], mosi_s};
  assign src_byte = stat_q ? status : mem_rdata;
  assign src_bit  = src_byte[3'd7 - bidx_q];

  always_comb begin
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    cmd_d  = cmd_q;
    ign_d  = ign_q;
    addr_d = addr_q;
    go_d   = go_q;
    stat_d = stat_q;
    bidx_d = bidx_q;
    miso_d = miso_q;
    oe_d   = oe_q;
    if (!sel) begin
      cnt_d  = '0;
      cmd_d  = CMD_NONE;
      ign_d  = 1'b0;
      go_d   = 1'b0;
      stat_d = 1'b0;
      bidx_d = '0;
      miso_d = 1'b0;
      oe_d   = 1'b0;
    end else begin
      if (sck_rise) begin
        sh_d = sh_n;
        if (cnt_q != '1) cnt_d = cnt_q + 1'b1;
        if (cnt_q == CNT_W'(OPC_BITS - 1)) begin
          cmd_d = decode_op(sh_n[7:0]);
          ign_d = busy && (cmd_d != CMD_RDSR);
          if (cmd_d == CMD_RDSR) begin
            go_d   = 1'b1;
            stat_d = 1'b1;
          end
        end
        if (cnt_q == CNT_W'(HDR_BITS - 1)) begin
          addr_d = sh_n[ADDR_W-1:0];
          if (cmd_q == CMD_READ && !ign_q) begin
            go_d   = 1'b1;
            stat_d = 1'b0;
          end
        end
      end
      if (sck_fall && go_q) begin
        miso_d = src_bit;
        oe_d   = 1'b1;
        bidx_d = bidx_q + 1'b1;
        if (bidx_q == 3'd7 && !stat_q) addr_d = addr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sh_q   <= '0;
      cmd_q  <= CMD_NONE;
      ign_q  <= 1'b0;
      addr_q <= '0;
      go_q   <= 1'b0;
      stat_q <= 1'b0;
      bidx_q <= '0;
      miso_q <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      cmd_q  <= cmd_d;
      ign_q  <= ign_d;
      addr_q <= addr_d;
      go_q   <= go_d;
      stat_q <= stat_d;
      bidx_q <= bidx_d;
      miso_q <= miso_d;
      oe_q   <= oe_d;
    end
  end

  assign cmd_addr     = addr_q;
  assign cmd_data     = sh_q[7:0];
  assign fe_wren      = frame_end && !ign_q && cmd_q == CMD_WREN && cnt_q == CNT_W'(OPC_BITS);
  assign fe_write     = frame_end && !ign_q && cmd_q == CMD_WRITE;
  assign fe_wrsr      = frame_end && !ign_q && cmd_q == CMD_WRSR;
  assign fe_full      = (cmd_q == CMD_WRITE && cnt_q == CNT_W'(WRITE_BITS)) ||
                        (cmd_q == CMD_WRSR  && cnt_q == CNT_W'(WRSR_BITS));
  assign is_status_wr = cmd_q == CMD_WRSR;
  assign miso         = miso_q;
  assign miso_oe      = oe_q;

  a_r12_oe_drops: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !miso_oe);

  a_r8_ignored_silent: assert property (@(posedge clk) disable iff (!rst_n)
    ign_q |-> !miso_oe);

  a_r3_no_early_data: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && cmd_q == CMD_READ && cnt_q < CNT_W'(HDR_BITS)) |-> !miso_oe);

endmodule

// File: rtl/ee_ctrl.sv
module ee_ctrl #(
  parameter int ADDR_W      = 10,
  parameter int PROG_CYCLES = 2000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fe_wren,
  input  logic              fe_write,
  input  logic              fe_wrsr,
  input  logic              fe_full,
  input  logic              prot_ok,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  output logic              busy,
  output logic [7:0]        status,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata,
  output logic [5:0]        cfg
);

  localparam int TW = $clog2(PROG_CYCLES + 1);

  logic          wel_q, wel_d;
  logic [5:0]    cfg_q, cfg_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          commit_mem, commit_st, start;

  assign commit_mem = fe_write && fe_full && wel_q && prot_ok;
  assign commit_st  = fe_wrsr  && fe_full && wel_q && prot_ok;
  assign start      = commit_mem || commit_st;

  always_comb begin
    wel_d = wel_q;
    if (fe_wren) wel_d = 1'b1;
    else if (fe_write || fe_wrsr) wel_d = 1'b0;

    cfg_d = cfg_q;
    if (commit_st) cfg_d = cmd_data[7:2];

    if (start) tmr_d = TW'(PROG_CYCLES);
    else if (tmr_q != '0) tmr_d = tmr_q - 1'b1;
    else tmr_d = tmr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q <= 1'b0;
      cfg_q <= '0;
      tmr_q <= '0;
    end else begin
      wel_q <= wel_d;
      cfg_q <= cfg_d;
      tmr_q <= tmr_d;
    end
  end

  assign busy      = tmr_q != '0;
  assign status    = {cfg_q, wel_q, busy};
  assign mem_we    = commit_mem;
  assign mem_waddr = cmd_addr;
  assign mem_wdata = cmd_data;
  assign cfg       = cfg_q;

  a_r5_commit_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || commit_st) |-> wel_q);

  a_r11_commit_needs_allow: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we || commit_st) |-> prot_ok);

  a_r7_busy_after_commit: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  a_r8_no_commit_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);

  a_r9_wel_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_write || fe_wrsr) |=> !wel_q);

  a_r10_cfg_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_st |=> $stable(cfg));

endmodule

// File: rtl/ee_mem.sv
module ee_mem #(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [7:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];

endmodule

// File: rtl/ee_spi_slave.sv
module ee_spi_slave #(
  parameter int ADDR_W      = 10,
  parameter int PROG_CYCLES = 2000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              miso,
  output logic              miso_oe,
  output logic [ADDR_W-1:0] prot_addr,
  output logic              prot_is_status,
  input  logic              prot_ok,
  output logic [5:0]        prot_cfg
);

  logic [1:0]        rst_pipe;
  logic              rst_int_n;
  logic              sel, sck_rise, sck_fall, mosi_s, frame_end;
  logic              busy, mem_we;
  logic [7:0]        status, mem_rdata, mem_wdata, cmd_data;
  logic [ADDR_W-1:0] cmd_addr, mem_waddr;
  logic              fe_wren, fe_write, fe_wrsr, fe_full;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  ee_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .cs_n_i   (cs_n),
    .sck_i    (sck),
    .mosi_i   (mosi),
    .sel      (sel),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall),
    .mosi_s   (mosi_s),
    .frame_end(frame_end)
  );

  ee_frame #(.ADDR_W(ADDR_W)) u_frame (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .sel         (sel),
    .sck_rise    (sck_rise),
    .sck_fall    (sck_fall),
    .mosi_s      (mosi_s),
    .frame_end   (frame_end),
    .busy        (busy),
    .status      (status),
    .mem_rdata   (mem_rdata),
    .cmd_addr    (cmd_addr),
    .cmd_data    (cmd_data),
    .fe_wren     (fe_wren),
    .fe_write    (fe_write),
    .fe_wrsr     (fe_wrsr),
    .fe_full     (fe_full),
    .is_status_wr(prot_is_status),
    .miso        (miso),
    .miso_oe     (miso_oe)
  );

  ee_ctrl #(.ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .fe_wren  (fe_wren),
    .fe_write (fe_write),
    .fe_wrsr  (fe_wrsr),
    .fe_full  (fe_full),
    .prot_ok  (prot_ok),
    .cmd_addr (cmd_addr),
    .cmd_data (cmd_data),
    .busy     (busy),
    .status   (status),
    .mem_we   (mem_we),
    .mem_waddr(mem_waddr),
    .mem_wdata(mem_wdata),
    .cfg      (prot_cfg)
  );

  ee_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wdata(mem_wdata),
    .raddr(cmd_addr),
    .rdata(mem_rdata)
  );

  assign prot_addr = cmd_addr;

  a_r12_oe_needs_select: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso_oe);

endmodule

// File: tb/sim_ee_spi_slave.sv
module sim_ee_spi_slave;

  localparam int CLK_NS = 10;
  localparam int HALF   = 8;
  localparam int AW     = 10;
  localparam int PROG   = 2000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1;
  logic          sck = 1'b0;
  logic          mosi = 1'b0;
  logic          miso, miso_oe;
  logic [AW-1:0] prot_addr;
  logic          prot_is_status;
  logic          prot_ok;
  logic [5:0]    prot_cfg;
  logic          deny_on = 1'b0;
  logic          st_allow = 1'b1;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic oe_seen;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs_q[$];

  always #(CLK_NS/2) clk = ~clk;

  // protection unit model: addresses 0x200..0x2FF refused while deny_on
  assign prot_ok = prot_is_status ? st_allow : !(deny_on && prot_addr[9:8] == 2'b10);

  ee_spi_slave #(.ADDR_W(AW), .PROG_CYCLES(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .prot_addr(prot_addr),
    .prot_is_status(prot_is_status), .prot_ok(prot_ok), .prot_cfg(prot_cfg)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, input int nb, output logic [7:0] rx);
    rx = 8'h00;
    for (int i = 7; i >= 8 - nb; i--) begin
      mosi = tx[i];
      idle(HALF);
      rx[i] = miso;
      oe_seen = oe_seen | miso_oe;
      sck = 1'b1;
      idle(HALF);
      sck = 1'b0;
    end
  endtask

  task automatic cs_lo();
    oe_seen = 1'b0;
    cs_n = 1'b0;
    idle(HALF);
  endtask

  task automatic cs_hi();
    idle(HALF);
    cs_n = 1'b1;
    idle(3 * HALF);
  endtask

  task automatic send(input logic [7:0] b);
    logic [7:0] d;
    xfer(b, 8, d);
  endtask

  // driver side of the scoreboard
  task automatic rd_byte(input logic [7:0] exp, input string tag);
    logic [7:0] d;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    xfer(8'h00, 8, d);
    obs_q.push_back(d);
  endtask

  task automatic wren();
    cs_lo(); send(8'h06); cs_hi();
  endtask

  task automatic rdsr(input logic [7:0] exp, input string tag);
    cs_lo(); send(8'h05); rd_byte(exp, tag); cs_hi();
  endtask

  task automatic rd_start(input logic [15:0] a);
    cs_lo(); send(8'h03); send(a[15:8]); send(a[7:0]);
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d, input int nb, input bit extra);
    logic [7:0] r;
    cs_lo(); send(8'h02); send(a[15:8]); send(a[7:0]);
    xfer(d, nb, r);
    if (extra) xfer(8'h80, 1, r);
    cs_hi();
  endtask

  task automatic wait_prog();
    idle(PROG + 50);
  endtask

  // monitor side of the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      while (obs_q.size() > 0 && exp_q.size() > 0) begin
        logic [7:0] o, e;
        string t;
        o = obs_q.pop_front();
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, {24'h0, o}, {24'h0, e});
      end
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    idle(10);

    // R1 reset state
    chk("R1 oe", {31'h0, miso_oe}, 0);
    chk("R1 cfg", {26'h0, prot_cfg}, 0);
    rdsr(8'h00, "R1 status");

    // R2 and R13: set enable flag, status read repeats
    wren();
    cs_lo(); send(8'h05);
    rd_byte(8'h02, "R2 wel");
    rd_byte(8'h02, "R13 repeat");
    cs_hi();
    chk("R12 idle oe", {31'h0, miso_oe}, 0);

    // R7 and R9: commit, busy, enable flag cleared
    wr(16'h0010, 8'h3C, 8, 1'b0);
    rdsr(8'h01, "R7 busy set R9");
    wait_prog();
    rdsr(8'h00, "R7 busy clear");

    // R8: lockout while busy
    wren();
    wr(16'h0011, 8'hC3, 8, 1'b0);
    rd_start(16'h0010);
    rd_byte(8'h00, "R8 read ignored");
    cs_hi();
    chk("R8 oe stays low", {31'h0, oe_seen}, 0);
    wren();
    wait_prog();
    rdsr(8'h00, "R8 wren ignored");

    // R3 and R4: read with increment
    rd_start(16'h0010);
    rd_byte(8'h3C, "R3 first byte");
    rd_byte(8'hC3, "R4 next byte");
    cs_hi();
    chk("R3 oe driven", {31'h0, oe_seen}, 1);

    // R5: no enable flag
    wr(16'h0010, 8'h77, 8, 1'b0);
    rdsr(8'h00, "R5 no busy");
    rd_start(16'h0010); rd_byte(8'h3C, "R5 unchanged"); cs_hi();

    // R6: one bit short, one bit over
    wren();
    wr(16'h0010, 8'h99, 7, 1'b0);
    rdsr(8'h00, "R6 short R9");
    rd_start(16'h0010); rd_byte(8'h3C, "R6 short unchanged"); cs_hi();
    wren();
    wr(16'h0010, 8'h99, 8, 1'b1);
    rdsr(8'h00, "R6 long R9");
    rd_start(16'h0010); rd_byte(8'h3C, "R6 long unchanged"); cs_hi();

    // R4 wrap and R3 high address bits ignored
    wren(); wr(16'h03FF, 8'hA5, 8, 1'b0); wait_prog();
    wren(); wr(16'h0000, 8'h5A, 8, 1'b0); wait_prog();
    rd_start(16'h03FF);
    rd_byte(8'hA5, "R4 top");
    rd_byte(8'h5A, "R4 wrap");
    cs_hi();
    rd_start(16'hFC00); rd_byte(8'h5A, "R3 alias"); cs_hi();

    // R11 protection refusal
    wren(); wr(16'h0250, 8'h11, 8, 1'b0); wait_prog();
    deny_on = 1'b1;
    wren();
    cs_lo(); send(8'h02); send(8'h02); send(8'h50); send(8'h22);
    chk("R11 addr", {22'h0, prot_addr}, 32'h250);
    chk("R11 kind", {31'h0, prot_is_status}, 0);
    cs_hi();
    rdsr(8'h00, "R11 refused");
    rd_start(16'h0250); rd_byte(8'h11, "R11 unchanged"); cs_hi();
    deny_on = 1'b0;

    // R10 status write
    wren();
    cs_lo(); send(8'h01); send(8'hFF);
    chk("R11 status kind", {31'h0, prot_is_status}, 1);
    cs_hi();
    wait_prog();
    rdsr(8'hFC, "R10 low bits kept");
    chk("R10 cfg", {26'h0, prot_cfg}, 32'h3F);
    st_allow = 1'b0;
    wren();
    cs_lo(); send(8'h01); send(8'h00); cs_hi();
    rdsr(8'hFC, "R11 status refused");
    chk("R11 cfg kept", {26'h0, prot_cfg}, 32'h3F);

    idle(20);
    chk("R3 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule